// File: doc/BRIEF.md
# Priority-Level Interrupt Controller

This block decides which interrupt request a processor core should take next. Each request line belongs to one of two groups. The debug group holds the first `N_DBG` indices and the peripheral group holds the rest. Every source has a 2-bit select field. The value 00 turns the source off. The other three values place it on one of four priority levels, and the group decides which three levels are reachable. One arbiter per level picks a candidate, and the highest occupied level wins. The winner is compared against the core's current mask level. If it qualifies, the block raises `irq` and presents a vector address derived from a programmable base.

A lowest-priority software request sits below every hardware level. It is taken only when no enabled hardware source is pending. The block also drives `wake`, which tells the clock-control logic that a qualifying interrupt exists, so that clocks restart from wait or stop states. The vector and `irq` are registered. Once `irq` is raised it holds, with a frozen vector, until the core acknowledges it.

Top module: `icp_intc`

## Requirements
- R1: After reset `irq` and `wake` are 0, `irq_vector` is 0, the vector base reads 0, and every select field reads 00.
- R2: A source whose select field is 00 never causes `irq` or `wake`, whatever its request line does.
- R3: A debug source (index below `N_DBG`) with select code 01, 10 or 11 sits at level 1, 2 or 3 respectively.
- R4: A peripheral source (index `N_DBG` or above) with select code 01, 10 or 11 sits at level 0, 1 or 2 respectively.
- R5: Among the enabled pending sources, the highest level wins. Within one level, the lowest index wins.
- R6: A hardware winner qualifies only when its level is greater than or equal to `core_mask`.
- R7: The vector of a hardware winner is base + 2 × index. The vector of the software request is base + 2 × N. Both are taken modulo 2^`VEC_W`.
- R8: The low software request qualifies only when `core_mask` is 0 and no enabled hardware source is pending. Any enabled pending source takes precedence over it.
- R9: When `irq` is low, the clock edge that samples a qualifying request sets `irq` and the vector. The edge is one register stage after the request.
- R10: While `irq` is high and `irq_ack` is low, `irq` stays high and the vector holds. An edge with `irq_ack` high clears `irq` and keeps the vector. Arbitration resumes on the following edge.
- R11: `wake` is registered every cycle from the qualifying condition (R6, R8), independent of the hold state of `irq`.
- R12: Register map and timing:
  - Address 0 holds the vector base.
  - Address 1+k holds the fields of sources 8k to 8k+7. Source 8k+j uses bits [2j+1:2j].
  - `cfg_rdata` reads the addressed word combinationally.
  - Writes to addresses above the last field word change nothing.
  - A write becomes visible to arbitration on the edge after it is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | N | Level-sensitive hardware requests |
| swi_low_req | input | 1 | Lowest-priority software request |
| core_mask | input | 2 | Current core mask level |
| irq_ack | input | 1 | Core accepts the presented interrupt |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data |
| irq | output | 1 | Interrupt to the core |
| irq_vector | output | VEC_W | Vector address of the presented interrupt |
| wake | output | 1 | Clock restart request |

## Verification
Two collisions are provoked on purpose. The first is an acknowledge landing in the same cycle as a newly qualifying, higher-priority request. The bench expects `irq` to fall for exactly one edge and then rise with the new vector. The second is a register write landing in the same cycle as a request that the write enables or re-levels. The bench expects the old setting to govern that edge and the new one to govern the next. A behavioural reference model, built from searches over integers, predicts `irq`, `irq_vector` and `wake` for every clock, including a long random run that mixes writes, acknowledges and mask changes.

// File: rtl/icp_pkg.sv
package icp_pkg;
    localparam int FIELDS_PER_WORD = 8;
    localparam int SEL_W           = 2;
    localparam int NUM_LEVELS      = 4;
    localparam int WORD_W          = FIELDS_PER_WORD * SEL_W;

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [1:0]       lvl_t;

    localparam sel_t SEL_OFF = 2'b00;
endpackage

// File: rtl/icp_cfg_regs.sv
module icp_cfg_regs
    import icp_pkg::*;
#(
    parameter int N      = 16,
    parameter int VEC_W  = 16,
    parameter int AW     = 2,
    localparam int NW    = (N + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        addr,
    input  logic [WORD_W-1:0]    wdata,
    output logic [WORD_W-1:0]    rdata,
    output logic [SEL_W*N-1:0]   sel_flat,
    output logic [VEC_W-1:0]     vec_base
);

    typedef struct packed {
        logic [SEL_W*N-1:0] sel;
        logic [VEC_W-1:0]   base;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (addr == '0) begin
                cfg_d.base = VEC_W'(wdata);
            end
            for (int k = 0; k < NW; k++) begin
                if (addr == AW'(k + 1)) begin
                    for (int j = 0; j < FIELDS_PER_WORD; j++) begin
                        if (k * FIELDS_PER_WORD + j < N) begin
                            cfg_d.sel[SEL_W*(k*FIELDS_PER_WORD+j) +: SEL_W] = wdata[SEL_W*j +: SEL_W];
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == '0) begin
            rdata = WORD_W'(cfg_q.base);
        end
        for (int k = 0; k < NW; k++) begin
            if (addr == AW'(k + 1)) begin
                for (int j = 0; j < FIELDS_PER_WORD; j++) begin
                    if (k * FIELDS_PER_WORD + j < N) begin
                        rdata[SEL_W*j +: SEL_W] = cfg_q.sel[SEL_W*(k*FIELDS_PER_WORD+j) +: SEL_W];
                    end
                end
            end
        end
    end

    assign sel_flat = cfg_q.sel;
    assign vec_base = cfg_q.base;

    AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr > AW'(NW)) |=> ($stable(sel_flat) && $stable(vec_base))); // R12

endmodule

// File: rtl/icp_level_map.sv
module icp_level_map
    import icp_pkg::*;
#(
    parameter int N     = 16,
    parameter int N_DBG = 4
) (
    input  logic [SEL_W*N-1:0] sel_flat,
    output logic [N-1:0]       src_en,
    output logic [2*N-1:0]     lvl_flat
);

    for (genvar i = 0; i < N; i++) begin : g_src
        sel_t code;
        assign code      = sel_flat[SEL_W*i +: SEL_W];
        assign src_en[i] = (code != SEL_OFF);
        if (i < N_DBG) begin : g_dbg
            // debug group: codes 1..3 land on levels 1..3
            assign lvl_flat[2*i +: 2] = lvl_t'(code);
        end else begin : g_per
            // peripheral group: codes 1..3 land on levels 0..2
            assign lvl_flat[2*i +: 2] = (code == SEL_OFF) ? 2'd0 : lvl_t'(code - 2'd1);
        end
    end

endmodule

// File: rtl/icp_arbiter.sv
module icp_arbiter
    import icp_pkg::*;
#(
    parameter int N      = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    input  logic [N-1:0]     src_en,
    input  logic [2*N-1:0]   lvl_flat,
    output logic             win_valid,
    output lvl_t             win_lvl,
    output logic [IDX_W-1:0] win_idx
);

    logic             lvl_hit [NUM_LEVELS];
    logic [IDX_W-1:0] lvl_idx [NUM_LEVELS];

    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
        logic [N-1:0]     elig;
        logic             hit;
        logic [IDX_W-1:0] idx;
        always_comb begin
            for (int i = 0; i < N; i++) begin
                elig[i] = req[i] && src_en[i] && (lvl_flat[2*i +: 2] == lvl_t'(l));
            end
            hit = |elig;
            idx = '0;
            for (int i = N - 1; i >= 0; i--) begin
                if (elig[i]) idx = IDX_W'(i);
            end
        end
        assign lvl_hit[l] = hit;
        assign lvl_idx[l] = idx;
    end

    always_comb begin
        win_valid = 1'b0;
        win_lvl   = '0;
        win_idx   = '0;
        for (int l = 0; l < NUM_LEVELS; l++) begin
            if (lvl_hit[l]) begin
                win_valid = 1'b1;
                win_lvl   = lvl_t'(l);
                win_idx   = lvl_idx[l];
            end
        end
        if (win_valid) begin
            AST_WINNER_ELIGIBLE: assert (req[win_idx] && src_en[win_idx]); // R5
        end
    end

endmodule

// File: rtl/icp_intc.sv
module icp_intc
    import icp_pkg::*;
#(
    parameter int N_DBG   = 4,
    parameter int N_PER   = 12,
    parameter int VEC_W   = 16,
    localparam int N      = N_DBG + N_PER,
    localparam int NW     = (N + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD,
    localparam int CFG_AW = $clog2(NW + 2),
    localparam int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      src_req,
    input  logic              swi_low_req,
    input  logic [1:0]        core_mask,
    input  logic              irq_ack,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    output logic              irq,
    output logic [VEC_W-1:0]  irq_vector,
    output logic              wake
);

    typedef struct packed {
        logic             irq;
        logic             wake;
        logic [VEC_W-1:0] vec;
    } state_t;

    logic [SEL_W*N-1:0] sel_flat;
    logic [VEC_W-1:0]   vec_base;
    logic [N-1:0]       src_en;
    logic [2*N-1:0]     lvl_flat;
    logic               win_valid;
    lvl_t               win_lvl;
    logic [IDX_W-1:0]   win_idx;

    icp_cfg_regs #(.N(N), .VEC_W(VEC_W), .AW(CFG_AW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .sel_flat (sel_flat),
        .vec_base (vec_base)
    );

    icp_level_map #(.N(N), .N_DBG(N_DBG)) u_map (
        .sel_flat (sel_flat),
        .src_en   (src_en),
        .lvl_flat (lvl_flat)
    );

    icp_arbiter #(.N(N)) u_arb (
        .req       (src_req),
        .src_en    (src_en),
        .lvl_flat  (lvl_flat),
        .win_valid (win_valid),
        .win_lvl   (win_lvl),
        .win_idx   (win_idx)
    );

    state_t st_d, st_q;
    logic             hw_ok, sw_ok, qualify;
    logic [VEC_W-1:0] cand_vec;

    always_comb begin
        hw_ok    = win_valid && (win_lvl >= core_mask);
        sw_ok    = swi_low_req && !win_valid && (core_mask == 2'd0);
        qualify  = hw_ok || sw_ok;
        cand_vec = hw_ok ? (vec_base + (VEC_W'(win_idx) << 1))
                         : (vec_base + VEC_W'(2 * N));

        st_d      = st_q;
        st_d.wake = qualify;
        if (st_q.irq) begin
            if (irq_ack) st_d.irq = 1'b0;
        end else begin
            st_d.irq = qualify;
            if (qualify) st_d.vec = cand_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq        = st_q.irq;
    assign irq_vector = st_q.vec;
    assign wake       = st_q.wake;

    AST_HOLD_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> (irq && $stable(irq_vector))); // R10
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_ack) |=> !irq); // R10
    AST_RISE_WITH_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> wake); // R11
    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !swi_low_req && win_valid && (win_lvl < core_mask)) |=> !irq); // R6

endmodule

// File: tb/test_icp_intc.sv
module test_icp_intc;
    localparam int N_DBG = 4;
    localparam int N_PER = 12;
    localparam int N     = N_DBG + N_PER;
    localparam int NW    = 2;
    localparam int VMOD  = 65536;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] src_req = '0;
    logic        swi_low_req = 1'b0;
    logic [1:0]  core_mask = 2'd0;
    logic        irq_ack = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] cfg_rdata;
    logic        irq;
    logic [15:0] irq_vector;
    logic        wake;

    icp_intc #(.N_DBG(N_DBG), .N_PER(N_PER), .VEC_W(16)) i_icp_intc (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .swi_low_req(swi_low_req),
        .core_mask(core_mask), .irq_ack(irq_ack), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq), .irq_vector(irq_vector),
        .wake(wake)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit live = 0;
    string phase = "R1";

    // reference model state
    int m_sel [N];
    int m_base;
    bit e_irq, e_wake;
    int e_vec;

    function automatic int model_word(int a);
        int w;
        if (a == 0) return m_base;
        if (a > NW) return 0;
        w = 0;
        for (int j = 0; j < 8; j++) begin
            if ((a - 1) * 8 + j < N) w |= m_sel[(a - 1) * 8 + j] << (2 * j);
        end
        return w;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_sel[i] = 0;
            m_base = 0; e_irq = 0; e_wake = 0; e_vec = 0;
        end else begin
            int best_l, best_i, l, cand;
            bit qual;
            best_l = -1; best_i = 0; qual = 0; cand = 0;
            for (int i = 0; i < N; i++) begin
                if (src_req[i] && m_sel[i] != 0) begin
                    l = (i < N_DBG) ? m_sel[i] : m_sel[i] - 1;
                    if (l > best_l) begin best_l = l; best_i = i; end
                end
            end
            if (best_l >= 0 && best_l >= int'(core_mask)) begin
                qual = 1; cand = (m_base + 2 * best_i) % VMOD;
            end else if (best_l < 0 && swi_low_req && core_mask == 0) begin
                qual = 1; cand = (m_base + 2 * N) % VMOD;
            end
            if (e_irq) begin
                if (irq_ack) e_irq = 0;
            end else begin
                e_irq = qual;
                if (qual) e_vec = cand;
            end
            e_wake = qual;
            if (cfg_we) begin
                if (cfg_addr == 0) m_base = int'(cfg_wdata);
                else if (int'(cfg_addr) <= NW) begin
                    for (int j = 0; j < 8; j++) begin
                        if ((int'(cfg_addr) - 1) * 8 + j < N)
                            m_sel[(int'(cfg_addr) - 1) * 8 + j] = (int'(cfg_wdata) >> (2 * j)) & 3;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (live && !done) begin
            checks++;
            if (irq !== e_irq || int'(irq_vector) != e_vec || wake !== e_wake) begin
                fails++;
                $display("FAIL %s: irq/vec/wake actual %0b/%h/%0b expected %0b/%h/%0b",
                         phase, irq, irq_vector, wake, e_irq, e_vec[15:0], e_wake);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = 2'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic rd_chk(int a, string tag);
        @(negedge clk);
        cfg_we = 0; cfg_addr = 2'(a);
        #1;
        checks++;
        if (int'(cfg_rdata) != model_word(a)) begin
            fails++;
            $display("FAIL %s: read addr %0d actual %h expected %h", tag, a, cfg_rdata, model_word(a));
        end
    endtask

    task automatic ack_pulse();
        @(negedge clk); irq_ack = 1;
        @(negedge clk); irq_ack = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not end, actual running expected done");
        finish_run();
    end

    initial begin
        cyc(2);
        rst_n = 1;
        #1;
        phase = "R1";
        checks++;
        if (irq !== 0 || irq_vector !== 0 || wake !== 0) begin
            fails++;
            $display("FAIL R1: reset outputs actual %0b/%h/%0b expected 0/0000/0", irq, irq_vector, wake);
        end
        live = 1;
        rd_chk(0, "R1"); rd_chk(1, "R1"); rd_chk(2, "R1");

        // all fields 00: nothing may fire
        phase = "R2";
        @(negedge clk); src_req = '1; swi_low_req = 0;
        cyc(4);
        @(negedge clk); src_req = '0;

        phase = "R12";
        wr(0, 16'h1000);
        wr(1, 16'hF431);   // s0 lvl1, s2 lvl3, s5 lvl0, s6 lvl2, s7 lvl2
        wr(2, 16'h0302);   // s8 lvl1, s12 lvl2
        rd_chk(0, "R12"); rd_chk(1, "R12"); rd_chk(2, "R12");
        wr(3, 16'hFFFF);   // out of range, ignored
        rd_chk(0, "R12"); rd_chk(1, "R12"); rd_chk(2, "R12"); rd_chk(3, "R12");

        // peripheral level 0 blocked by mask 1, accepted at mask 0
        phase = "R6";
        @(negedge clk); core_mask = 1; src_req = 16'h0020;
        cyc(3);
        phase = "R4";
        @(negedge clk); core_mask = 0;
        cyc(3);
        ack_pulse();
        @(negedge clk); src_req = '0;
        cyc(2);

        // debug level 1 passes mask 1
        phase = "R3";
        @(negedge clk); core_mask = 1; src_req = 16'h0001;
        cyc(3); ack_pulse();
        @(negedge clk); src_req = '0; cyc(2);

        // ties and higher level
        phase = "R5";
        @(negedge clk); core_mask = 0; src_req = 16'h10C0;
        cyc(3); ack_pulse();
        @(negedge clk); src_req = 16'h10C4;
        cyc(3); ack_pulse();
        @(negedge clk); src_req = '0; cyc(2);

        // hold while pending, higher request arrives; then requests vanish
        phase = "R10";
        @(negedge clk); src_req = 16'h0020;
        cyc(2);
        @(negedge clk); src_req = 16'h0024;
        cyc(3);
        phase = "R11";
        @(negedge clk); src_req = '0;
        cyc(3);
        phase = "R10";
        // ack coincides with a fresh higher request
        @(negedge clk); irq_ack = 1; src_req = 16'h0004;
        @(negedge clk); irq_ack = 0;
        cyc(3); ack_pulse();
        @(negedge clk); src_req = '0; cyc(2);

        // low software request
        phase = "R8";
        @(negedge clk); swi_low_req = 1; core_mask = 0;
        cyc(3); ack_pulse();
        @(negedge clk); src_req = 16'h0020;
        cyc(3); ack_pulse();
        @(negedge clk); src_req = '0; core_mask = 1;
        cyc(3);
        @(negedge clk); swi_low_req = 0; core_mask = 0; cyc(2);

        // write and request in the same cycle
        phase = "R12";
        @(negedge clk); src_req = 16'h0200; cfg_we = 1; cfg_addr = 2; cfg_wdata = 16'h030E;
        @(negedge clk); cfg_we = 0;
        cyc(3); ack_pulse();
        @(negedge clk); src_req = '0; cyc(2);

        // vector wrap
        phase = "R7";
        wr(0, 16'hFFF8);
        @(negedge clk); src_req = 16'h1000;
        cyc(3); ack_pulse();
        @(negedge clk); src_req = '0; cyc(1);
        @(negedge clk); swi_low_req = 1;
        cyc(3); ack_pulse();
        @(negedge clk); swi_low_req = 0; cyc(2);

        // random mix
        phase = "R9";
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            src_req     = 16'($urandom) & 16'($urandom);
            swi_low_req = 1'($urandom);
            core_mask   = 2'($urandom);
            irq_ack     = ($urandom % 4) == 0;
            cfg_we      = ($urandom % 16) == 0;
            cfg_addr    = 2'($urandom);
            cfg_wdata   = 16'($urandom);
        end
        @(negedge clk);
        cfg_we = 0; irq_ack = 0; src_req = '0; swi_low_req = 0;
        cyc(3);
        rd_chk(0, "R12"); rd_chk(1, "R12"); rd_chk(2, "R12");
        finish_run();
    end

endmodule